// File: doc/BRIEF.md
# Aliased register bank for a temperature monitor

This block holds the software-visible state of a small on-chip temperature monitor: two control words, a status word, an alarm threshold, a measurement period, a clock divider, a power-up delay and two calibration trim words. It also holds a read-only sample word. Software reaches it over a simple valid/ready register bus. Internal logic reads every register through dedicated output ports, raises status bits through a per-bit set input, and loads new samples through a sample port.

Each writable register answers at four word addresses. The address bits [3:2] of an access select the write operation. A plain write replaces the register. The other three operations OR in the write data, clear the bits that are 1 in the write data, or invert those bits. Software can therefore change one field without a read-modify-write sequence, and cannot race another agent on the other bits. A status bit that hardware sets in the same cycle that software clears it stays set, so no event is lost.

Top module: `mon_regbank`

## Requirements
- R1: A write to a register base address (address bits [3:2] = 00) replaces the whole register with the write data.
- R2: A write to base+0x4 (bits [3:2] = 01) ORs the write data into the register.
- R3: A write to base+0x8 (bits [3:2] = 10) clears each register bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to base+0xC (bits [3:2] = 11) inverts each register bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A read from any of the four addresses of a register returns that register's current contents.
- R6: The writable registers have these base addresses: control A 0x000, status 0x010, threshold 0x030, control B 0x200, period 0x270, divider 0x280, power-up delay 0x2B0. They reset to zero.
- R7: The trim words at 0x2E0 and 0x2F0 reset to 0xB561BC2D and 0x65D4. A plain write replaces them.
- R8: The sample word at 0x020 (and its aliases) holds the last value on sample_i taken when sample_valid_i was high, and it resets to zero. A read returns that value in bits [15:0] with bit 15 copied into bits [31:16]. Writes to the sample word are ignored.
- R9: A 1 on bit n of stat_set_i sets status bit n in the next cycle. If a software clear or a plain write hits the same bit in the same cycle, the bit still ends up set.
- R10: A read of an unmapped address, or of an address with bits [1:0] not zero, returns 0. A write to such an address changes no register. Both still complete the handshake.
- R11: req_ready_o rises one cycle after req_valid_i and stays high for one cycle. The transfer takes place in the cycle where both are high. req_rdata_o holds the read result during that cycle.
- R12: Each writable register's contents appear on its output port from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request, held until accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Access accepted this cycle |
| req_rdata_o | output | 32 | Read data, valid while req_ready_o is high |
| stat_set_i | input | 32 | Per-bit hardware set for the status word |
| sample_valid_i | input | 1 | Load sample_i into the sample word |
| sample_i | input | 16 | Signed temperature sample |
| ctrl_a_o | output | 32 | Control A contents |
| stat_o | output | 32 | Status contents |
| thresh_o | output | 32 | Threshold contents |
| ctrl_b_o | output | 32 | Control B contents |
| period_o | output | 32 | Period contents |
| div_o | output | 32 | Divider contents |
| pud_o | output | 32 | Power-up delay contents |
| trim_a_o | output | 32 | First trim word |
| trim_b_o | output | 32 | Second trim word |

## Verification
The bench issues random writes with random data to every register through all four aliases, then reads each result back through a randomly chosen alias and compares it with a reference model. Random data with about half its bits set separates OR, AND-NOT and XOR from a plain write, and it catches an alias that is decoded to the wrong register. Status accesses are mixed with random hardware sets in the same cycle, which shows that set beats clear. Directed cases cover the reset values and negative and positive samples, which show the sign extension. They also cover unmapped and misaligned addresses, where a write must leave every register unchanged.

// File: rtl/mon_regbank_pkg.sv
package mon_regbank_pkg;
  localparam int DW = 32;
  localparam int N_RW = 9;
  localparam int IDX_W = 4;
  localparam int IDX_STAT = 1;
  localparam logic [11:0] SAMPLE_BASE = 12'h020;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } alias_op_e;

  function automatic logic [11:0] rw_base(int i);
    case (i)
      0:       return 12'h000;
      1:       return 12'h010;
      2:       return 12'h030;
      3:       return 12'h200;
      4:       return 12'h270;
      5:       return 12'h280;
      6:       return 12'h2B0;
      7:       return 12'h2E0;
      default: return 12'h2F0;
    endcase
  endfunction

  function automatic logic [DW-1:0] apply_op(alias_op_e op, logic [DW-1:0] cur,
                                             logic [DW-1:0] wd);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/mon_bus_if.sv
module mon_bus_if (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic ready_o,
  output logic capture_o,
  output logic commit_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= valid_i & ~ack_q;
  end

  assign ready_o   = ack_q;
  assign capture_o = valid_i & ~ack_q;
  assign commit_o  = valid_i & ack_q;

  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R11
  AST_READY_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_o) |=> ready_o); // R11
endmodule

// File: rtl/mon_addr_dec.sv
module mon_addr_dec
  import mon_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_rw_o,
  output logic              hit_sample_o,
  output logic [IDX_W-1:0]  idx_o,
  output alias_op_e         op_o
);
  logic [ADDR_W-1:0] base;
  logic              aligned;

  assign base    = {addr_i[ADDR_W-1:4], 4'h0};
  assign aligned = (addr_i[1:0] == 2'b00);
  assign op_o    = alias_op_e'(addr_i[3:2]);

  always_comb begin
    hit_rw_o = 1'b0;
    idx_o    = '0;
    for (int i = 0; i < N_RW; i++) begin
      if (aligned && base == ADDR_W'(rw_base(i))) begin
        hit_rw_o = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
    hit_sample_o = aligned && (base == ADDR_W'(SAMPLE_BASE));
  end
endmodule

// File: rtl/mon_alias_reg.sv
module mon_alias_reg
  import mon_regbank_pkg::*;
#(
  parameter logic [DW-1:0] RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  alias_op_e     op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] hw_set_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (we_i) q_d = apply_op(op_i, q_q, wdata_i);
    q_d = q_d | hw_set_i; // hardware set beats software clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((q_o & $past(hw_set_i)) == $past(hw_set_i))); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && hw_set_i == '0) |=> $stable(q_o)); // R12
  AST_SET_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_SET) |=> ((q_o & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_CLR_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_CLR && hw_set_i == '0) |=> ((q_o & $past(wdata_i)) == '0)); // R3
  AST_TOG_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_TOG && hw_set_i == '0) |=> (q_o == ($past(q_o) ^ $past(wdata_i)))); // R4
endmodule

// File: rtl/mon_regbank.sv
module mon_regbank
  import mon_regbank_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              SAMPLE_W  = 16,
  parameter logic [DW-1:0]   TRIM_A_RST = 32'hB561BC2D,
  parameter logic [DW-1:0]   TRIM_B_RST = 32'h000065D4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DW-1:0]       req_wdata_i,
  output logic                req_ready_o,
  output logic [DW-1:0]       req_rdata_o,
  input  logic [DW-1:0]       stat_set_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [DW-1:0]       ctrl_a_o,
  output logic [DW-1:0]       stat_o,
  output logic [DW-1:0]       thresh_o,
  output logic [DW-1:0]       ctrl_b_o,
  output logic [DW-1:0]       period_o,
  output logic [DW-1:0]       div_o,
  output logic [DW-1:0]       pud_o,
  output logic [DW-1:0]       trim_a_o,
  output logic [DW-1:0]       trim_b_o
);
  localparam int EXT_W = DW - SAMPLE_W;

  logic          capture, commit;
  logic          hit_rw, hit_sample;
  logic [IDX_W-1:0] idx;
  alias_op_e     op;
  logic [DW-1:0] rw_q [N_RW];
  logic [DW-1:0] rd_word, rdata_q;
  logic [SAMPLE_W-1:0] sample_q;

  mon_bus_if u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_valid_i),
    .ready_o   (req_ready_o),
    .capture_o (capture),
    .commit_o  (commit)
  );

  mon_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i       (req_addr_i),
    .hit_rw_o     (hit_rw),
    .hit_sample_o (hit_sample),
    .idx_o        (idx),
    .op_o         (op)
  );

  for (genvar i = 0; i < N_RW; i++) begin : g_reg
    localparam logic [DW-1:0] RST_V = (i == 7) ? TRIM_A_RST :
                                      (i == 8) ? TRIM_B_RST : '0;
    logic          we;
    logic [DW-1:0] hs;
    assign we = commit & req_write_i & hit_rw & (idx == IDX_W'(i));
    if (i == IDX_STAT) begin : g_hs
      assign hs = stat_set_i;
    end else begin : g_nohs
      assign hs = '0;
    end
    mon_alias_reg #(.RST(RST_V)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we),
      .op_i     (op),
      .wdata_i  (req_wdata_i),
      .hw_set_i (hs),
      .q_o      (rw_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sample_q <= '0;
    else if (sample_valid_i) sample_q <= sample_i;
  end

  always_comb begin
    rd_word = '0;
    if (hit_rw)          rd_word = rw_q[idx];
    else if (hit_sample) rd_word = {{EXT_W{sample_q[SAMPLE_W-1]}}, sample_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= rd_word;
  end

  assign req_rdata_o = rdata_q;
  assign ctrl_a_o    = rw_q[0];
  assign stat_o      = rw_q[1];
  assign thresh_o    = rw_q[2];
  assign ctrl_b_o    = rw_q[3];
  assign period_o    = rw_q[4];
  assign div_o       = rw_q[5];
  assign pud_o       = rw_q[6];
  assign trim_a_o    = rw_q[7];
  assign trim_b_o    = rw_q[8];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && !hit_rw && !hit_sample) |=> (req_rdata_o == '0)); // R10
  AST_SAMPLE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && hit_sample) |=> (req_rdata_o[DW-1:SAMPLE_W] == {EXT_W{req_rdata_o[SAMPLE_W-1]}})); // R8
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && req_write_i && !hit_rw && stat_set_i == '0) |=> ($stable(ctrl_a_o) && $stable(stat_o) && $stable(trim_b_o))); // R10
endmodule

// File: tb/tb_mon_regbank.sv
module tb_mon_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, stat_set = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        smp_v = 1'b0;
  logic [15:0] smp = '0;
  logic [31:0] o_ca, o_st, o_th, o_cb, o_pe, o_dv, o_pu, o_ta, o_tb;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_q [9];
  logic [15:0] exp_smp;

  always #2 clk = ~clk;

  mon_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready), .req_rdata_o(rdata),
    .stat_set_i(stat_set), .sample_valid_i(smp_v), .sample_i(smp),
    .ctrl_a_o(o_ca), .stat_o(o_st), .thresh_o(o_th), .ctrl_b_o(o_cb), .period_o(o_pe),
    .div_o(o_dv), .pud_o(o_pu), .trim_a_o(o_ta), .trim_b_o(o_tb)
  );

  function automatic logic [11:0] base_of(int i);
    case (i)
      0: return 12'h000; 1: return 12'h010; 2: return 12'h030;
      3: return 12'h200; 4: return 12'h270; 5: return 12'h280;
      6: return 12'h2B0; 7: return 12'h2E0; default: return 12'h2F0;
    endcase
  endfunction

  function automatic logic [31:0] port_of(int i);
    case (i)
      0: return o_ca; 1: return o_st; 2: return o_th; 3: return o_cb;
      4: return o_pe; 5: return o_dv; 6: return o_pu; 7: return o_ta;
      default: return o_tb;
    endcase
  endfunction

  function automatic logic [31:0] model_op(int op, logic [31:0] cur, logic [31:0] wd);
    case (op)
      1: return cur | wd;
      2: return cur & ~wd;
      3: return cur ^ wd;
      default: return wd;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                      input logic [31:0] hs, output logic [31:0] rd, output int n);
    @(negedge clk);
    valid = 1'b1; write = wr; addr = a; wdata = wd; n = 0;
    do begin @(negedge clk); n++; end while (!ready && n < 8);
    rd = rdata;
    stat_set = hs;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; stat_set = '0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] r; int n;
    xfer(1'b0, a, '0, '0, r, n);
    chk(req, r, exp);
  endtask

  task automatic load_sample(logic [15:0] v);
    @(negedge clk); smp_v = 1'b1; smp = v;
    @(negedge clk); smp_v = 1'b0;
    exp_smp = v;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 9; i++) exp_q[i] = '0;
    exp_q[7] = 32'hB561BC2D;
    exp_q[8] = 32'h000065D4;
    exp_smp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 R7 R8 reset values
    chk("R11 ready idle", {31'd0, ready}, 32'd0);
    for (int i = 0; i < 9; i++) rd_chk(i >= 7 ? "R7 reset" : "R6 reset", base_of(i), exp_q[i]);
    rd_chk("R8 reset", 12'h020, 32'd0);

    // R11 handshake timing
    xfer(1'b1, 12'h000, 32'h0000_00F0, '0, r, n);
    exp_q[0] = 32'h0000_00F0;
    chk("R11 ready latency", n, 1);
    chk("R11 ready drops", {31'd0, ready}, 32'd0);
    chk("R1 plain write", o_ca, 32'h0000_00F0);
    xfer(1'b1, 12'h004, 32'h0000_0003, '0, r, n); exp_q[0] |= 32'h3;
    chk("R2 set alias", o_ca, 32'h0000_00F3);
    xfer(1'b1, 12'h008, 32'h0000_0030, '0, r, n); exp_q[0] &= ~32'h30;
    chk("R3 clear alias", o_ca, 32'h0000_00C3);
    xfer(1'b1, 12'h00C, 32'h0000_0101, '0, r, n); exp_q[0] ^= 32'h101;
    chk("R4 toggle alias", o_ca, 32'h0000_01C2);
    rd_chk("R5 alias read", 12'h008, 32'h0000_01C2);

    // R7 trim plain write
    xfer(1'b1, 12'h2E0, 32'h1234_5678, '0, r, n); exp_q[7] = 32'h1234_5678;
    rd_chk("R7 trim write", 12'h2E4, 32'h1234_5678);

    // R9 hw set vs sw clear same cycle
    xfer(1'b1, 12'h010, 32'hFFFF_FFFF, '0, r, n); exp_q[1] = '1;
    xfer(1'b1, 12'h018, 32'hFFFF_FFFF, 32'h0000_0200, r, n); exp_q[1] = 32'h200;
    chk("R9 set beats clear", o_st, 32'h0000_0200);
    xfer(1'b1, 12'h010, 32'h0, 32'h0000_2000, r, n); exp_q[1] = 32'h2000;
    chk("R9 set beats plain write", o_st, 32'h0000_2000);

    // R8 sample word
    load_sample(16'hFF80);
    rd_chk("R8 negative sample", 12'h020, 32'hFFFF_FF80);
    load_sample(16'h0A40);
    rd_chk("R8 positive sample alias", 12'h02C, 32'h0000_0A40);
    xfer(1'b1, 12'h020, 32'hDEAD_BEEF, '0, r, n);
    rd_chk("R8 write ignored", 12'h020, 32'h0000_0A40);

    // R10 unmapped / misaligned
    rd_chk("R10 unmapped read", 12'h040, 32'd0);
    rd_chk("R10 misaligned read", 12'h001, 32'd0);
    xfer(1'b1, 12'h044, 32'hFFFF_FFFF, '0, r, n);
    chk("R10 unmapped handshake", n, 1);
    xfer(1'b1, 12'h002, 32'hFFFF_FFFF, '0, r, n);
    xfer(1'b1, 12'h3F0, 32'hFFFF_FFFF, '0, r, n);
    for (int i = 0; i < 9; i++) rd_chk("R10 write ignored", base_of(i), exp_q[i]);

    // random alias traffic, R1-R5 R9 R12
    for (int k = 0; k < 400; k++) begin
      int i, op, rop;
      logic [31:0] wd, hs;
      i  = $urandom % 9;
      op = $urandom % 4;
      wd = $urandom;
      hs = ($urandom % 2) ? $urandom : 32'd0;
      xfer(1'b1, base_of(i) | 12'(op << 2), wd, hs, r, n);
      exp_q[i] = model_op(op, exp_q[i], wd);
      exp_q[1] = exp_q[1] | hs;
      chk("R12 output port", port_of(i), exp_q[i]);
      chk("R9 status port", o_st, exp_q[1]);
      rop = $urandom % 4;
      rd_chk("R5 random alias read", base_of(i) | 12'(rop << 2), exp_q[i]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule